// File: doc/BRIEF.md
# LCD Raster Timing Generator

This block produces the raster timing for an LCD panel. A pixel counter runs along each line and a line counter runs down each frame. Both start with the sync pulse at count zero, then pass through the back porch, the active region and the front porch. Every threshold is an absolute count measured from the start of the sync pulse. From the two counters the block drives horizontal sync, vertical sync and a display-enable strobe, with a separate polarity choice for each sync output.

The block reports the current line number. It also gives two status levels: one that is true while the panel is in vertical sync and one that is true while it is in vertical blanking. A programmable line number sets a sticky status flag when the raster reaches the start of that line. The flag drives an interrupt output through an enable bit and is cleared by a write-one pulse. The surrounding register file holds the configuration inputs. They are expected to change only while the generator is disabled.

Top module: `lcd_timing_gen`

## Requirements
- R1: While `enable` is high, `hCount` advances by one on every clock and returns to 0 on the clock after it equals `hTotal`-1, so a line is `hTotal` clocks long.
- R2: `lineNum` advances by one on each return of `hCount` to 0 and returns to 0 after the line `vTotal`-1, so a frame is `hTotal`*`vTotal` clocks long.
- R3: The horizontal sync is asserted while `hCount` < `hSyncEnd`. The vertical sync is asserted while `lineNum` < `vSyncEnd`.
- R4: `dispEn` is 1 exactly when `hDispStart` <= `hCount` < `hDispStart`+`hActive` and `vDispStart` <= `lineNum` < `vDispStart`+`vActive`.
- R5: `syncPol` bit 0 sets the polarity of `hSync` and bit 1 sets the polarity of `vSync`. For each bit, a value of 1 means the output is high while asserted and a value of 0 means it is low while asserted.
- R6: `vSyncStat` is 1 while `lineNum` < `vSyncEnd`. `vBlankStat` is 1 while `lineNum` < `vDispStart` or `lineNum` >= `vDispStart`+`vActive`.
- R7: On the clock edge at which `hCount` is 0 and `lineNum` equals `matchLine` (generator enabled), `matchStat` becomes 1 and stays 1. The output `irq` equals `matchStat` AND `irqEn`.
- R8: A high `matchClr` at a clock edge clears `matchStat`. If a line match occurs at the same edge, the set takes priority and `matchStat` stays 1.
- R9: While `enable` is low, both counters are held at 0, `dispEn` is 0, both syncs sit at their inactive level, `vSyncStat` is 0 and `vBlankStat` is 1. `matchStat` keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Run the counters; low holds them at 0 |
| hSyncEnd | input | H_W | Pixel count at which hsync ends |
| hDispStart | input | H_W | First active pixel count |
| hActive | input | H_W | Number of active pixels per line |
| hTotal | input | H_W | Clocks per line |
| vSyncEnd | input | V_W | Line at which vsync ends |
| vDispStart | input | V_W | First active line |
| vActive | input | V_W | Number of active lines |
| vTotal | input | V_W | Lines per frame |
| syncPol | input | 2 | Sync polarity, bit 0 horizontal, bit 1 vertical, 1 = active high |
| matchLine | input | V_W | Line that raises the match flag |
| irqEn | input | 1 | Lets the match flag drive `irq` |
| matchClr | input | 1 | Write-one-to-clear pulse for the match flag |
| hCount | output | H_W | Current pixel count within the line |
| lineNum | output | V_W | Current line number |
| hSync | output | 1 | Horizontal sync after polarity |
| vSync | output | 1 | Vertical sync after polarity |
| dispEn | output | 1 | Display enable |
| vSyncStat | output | 1 | Raster is in vertical sync |
| vBlankStat | output | 1 | Raster is in vertical blanking |
| matchStat | output | 1 | Sticky line-match flag |
| irq | output | 1 | Line-match interrupt |

## Verification
The assertions assume that `hTotal` and `vTotal` are at least 2. They also assume that the timing inputs do not change while `enable` is high, since the wrap and step properties compare the counters against those inputs across cycles. The bench changes configuration only while the generator is disabled. It then sweeps whole frames of two small, differently shaped rasters and predicts every output from the number of clocks since enable. The clear pulses are placed once away from a match and once on the exact match edge.

// File: rtl/lcd_timing_pkg.sv
package lcd_timing_pkg;
  typedef struct packed {
    logic clear;      // generator disabled, hold counters at zero
    logic hWrap;      // last pixel of the line
    logic vWrap;      // last pixel of the frame
    logic lineStart;  // first pixel of a line
  } tgStrobe_t;
endpackage

// File: rtl/lcd_timing_ctrl.sv
module lcd_timing_ctrl
  import lcd_timing_pkg::*;
#(
  parameter int H_W = 11,
  parameter int V_W = 10
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           enable,
  input  logic [H_W-1:0] hCount,
  input  logic [V_W-1:0] vCount,
  input  logic [H_W-1:0] hTotal,
  input  logic [V_W-1:0] vTotal,
  input  logic [V_W-1:0] matchLine,
  input  logic           irqEn,
  input  logic           matchClr,
  output tgStrobe_t      strb,
  output logic           matchStat,
  output logic           irq
);
  localparam logic [H_W-1:0] H_ONE = H_W'(1);
  localparam logic [V_W-1:0] V_ONE = V_W'(1);

  logic lastPix;
  logic lastLine;
  logic lineHit;

  always_comb begin
    lastPix        = (hCount == hTotal - H_ONE);
    lastLine       = (vCount == vTotal - V_ONE);
    strb.clear     = !enable;
    strb.hWrap     = enable && lastPix;
    strb.vWrap     = enable && lastPix && lastLine;
    strb.lineStart = enable && (hCount == '0);
    lineHit        = strb.lineStart && (vCount == matchLine);
  end

  // Sticky match flag: a set beats a clear in the same cycle (R7, R8)
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        matchStat <= 1'b0;
    else if (lineHit)  matchStat <= 1'b1;
    else if (matchClr) matchStat <= 1'b0;
  end

  assign irq = matchStat && irqEn;

  p_match_set_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && hCount == '0 && vCount == matchLine) |=> matchStat);

  p_match_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (matchStat && !matchClr) |=> matchStat);

  p_match_fall_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(matchStat) |-> $past(matchClr));
endmodule

// File: rtl/lcd_timing_dp.sv
module lcd_timing_dp
  import lcd_timing_pkg::*;
#(
  parameter int H_W = 11,
  parameter int V_W = 10
) (
  input  logic           clk,
  input  logic           rst_n,
  input  tgStrobe_t      strb,
  input  logic [H_W-1:0] hSyncEnd,
  input  logic [H_W-1:0] hDispStart,
  input  logic [H_W-1:0] hActive,
  input  logic [V_W-1:0] vSyncEnd,
  input  logic [V_W-1:0] vDispStart,
  input  logic [V_W-1:0] vActive,
  input  logic [1:0]     syncPol,
  output logic [H_W-1:0] hCount,
  output logic [V_W-1:0] vCount,
  output logic           hSync,
  output logic           vSync,
  output logic           dispEn,
  output logic           vSyncStat,
  output logic           vBlankStat
);
  localparam int HE_W = H_W + 1;
  localparam int VE_W = V_W + 1;

  logic [HE_W-1:0] hActEnd;
  logic [VE_W-1:0] vActEnd;
  logic inHSync, inVSync, inHAct, inVAct, running;

  // Counters
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hCount <= '0;
      vCount <= '0;
    end else if (strb.clear) begin
      hCount <= '0;
      vCount <= '0;
    end else if (strb.hWrap) begin
      hCount <= '0;
      vCount <= strb.vWrap ? '0 : vCount + V_W'(1);
    end else begin
      hCount <= hCount + H_W'(1);
    end
  end

  // Window decode
  always_comb begin
    running    = !strb.clear;
    hActEnd    = {1'b0, hDispStart} + {1'b0, hActive};
    vActEnd    = {1'b0, vDispStart} + {1'b0, vActive};
    inHSync    = running && (hCount < hSyncEnd);
    inVSync    = running && (vCount < vSyncEnd);
    inHAct     = ({1'b0, hCount} >= {1'b0, hDispStart}) && ({1'b0, hCount} < hActEnd);
    inVAct     = ({1'b0, vCount} >= {1'b0, vDispStart}) && ({1'b0, vCount} < vActEnd);
    dispEn     = running && inHAct && inVAct;
    hSync      = ~(inHSync ^ syncPol[0]);
    vSync      = ~(inVSync ^ syncPol[1]);
    vSyncStat  = inVSync;
    vBlankStat = !(running && inVAct);
  end

  p_hwrap_r1: assert property (@(posedge clk) disable iff (!rst_n)
    strb.hWrap |=> (hCount == '0));

  p_hstep_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (!strb.clear && !strb.hWrap) |=> (hCount == $past(hCount) + H_W'(1)));

  p_vstep_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (strb.hWrap && !strb.vWrap) |=> (vCount == $past(vCount) + V_W'(1)));

  p_vwrap_r2: assert property (@(posedge clk) disable iff (!rst_n)
    strb.vWrap |=> (vCount == '0));

  p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    strb.clear |=> (hCount == '0 && vCount == '0));
endmodule

// File: rtl/lcd_timing_gen.sv
module lcd_timing_gen
  import lcd_timing_pkg::*;
#(
  parameter int H_W = 11,
  parameter int V_W = 10
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           enable,
  input  logic [H_W-1:0] hSyncEnd,
  input  logic [H_W-1:0] hDispStart,
  input  logic [H_W-1:0] hActive,
  input  logic [H_W-1:0] hTotal,
  input  logic [V_W-1:0] vSyncEnd,
  input  logic [V_W-1:0] vDispStart,
  input  logic [V_W-1:0] vActive,
  input  logic [V_W-1:0] vTotal,
  input  logic [1:0]     syncPol,
  input  logic [V_W-1:0] matchLine,
  input  logic           irqEn,
  input  logic           matchClr,
  output logic [H_W-1:0] hCount,
  output logic [V_W-1:0] lineNum,
  output logic           hSync,
  output logic           vSync,
  output logic           dispEn,
  output logic           vSyncStat,
  output logic           vBlankStat,
  output logic           matchStat,
  output logic           irq
);
  tgStrobe_t strb;

  lcd_timing_ctrl #(.H_W(H_W), .V_W(V_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .enable(enable),
    .hCount(hCount), .vCount(lineNum),
    .hTotal(hTotal), .vTotal(vTotal),
    .matchLine(matchLine), .irqEn(irqEn), .matchClr(matchClr),
    .strb(strb), .matchStat(matchStat), .irq(irq)
  );

  lcd_timing_dp #(.H_W(H_W), .V_W(V_W)) u_dp (
    .clk(clk), .rst_n(rst_n), .strb(strb),
    .hSyncEnd(hSyncEnd), .hDispStart(hDispStart), .hActive(hActive),
    .vSyncEnd(vSyncEnd), .vDispStart(vDispStart), .vActive(vActive),
    .syncPol(syncPol),
    .hCount(hCount), .vCount(lineNum),
    .hSync(hSync), .vSync(vSync), .dispEn(dispEn),
    .vSyncStat(vSyncStat), .vBlankStat(vBlankStat)
  );
endmodule

// File: tb/lcd_timing_gen_tb.sv
module lcd_timing_gen_tb;
  localparam int H_W = 11;
  localparam int V_W = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic enable = 1'b0;
  logic [H_W-1:0] hSyncEnd = '0, hDispStart = '0, hActive = '0, hTotal = 11'd4;
  logic [V_W-1:0] vSyncEnd = '0, vDispStart = '0, vActive = '0, vTotal = 10'd4;
  logic [1:0] syncPol = 2'b00;
  logic [V_W-1:0] matchLine = '0;
  logic irqEn = 1'b0, matchClr = 1'b0;
  logic [H_W-1:0] hCount;
  logic [V_W-1:0] lineNum;
  logic hSync, vSync, dispEn, vSyncStat, vBlankStat, matchStat, irq;

  int nChecks = 0, nFails = 0;
  bit finished = 1'b0;
  bit expSticky = 1'b0;

  always #5 clk = ~clk;

  lcd_timing_gen #(.H_W(H_W), .V_W(V_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .enable(enable),
    .hSyncEnd(hSyncEnd), .hDispStart(hDispStart), .hActive(hActive), .hTotal(hTotal),
    .vSyncEnd(vSyncEnd), .vDispStart(vDispStart), .vActive(vActive), .vTotal(vTotal),
    .syncPol(syncPol), .matchLine(matchLine), .irqEn(irqEn), .matchClr(matchClr),
    .hCount(hCount), .lineNum(lineNum), .hSync(hSync), .vSync(vSync), .dispEn(dispEn),
    .vSyncStat(vSyncStat), .vBlankStat(vBlankStat), .matchStat(matchStat), .irq(irq)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s %s: actual %0d expected %0d at %0t", req, what, act, exp, $time);
    end
  endtask

  // Check all outputs against raster position (h, v); en is the enable state
  task automatic checkPos(input int h, input int v, input bit en);
    int hs, vs, hde, vde;
    hs  = en && (h < int'(hSyncEnd));
    vs  = en && (v < int'(vSyncEnd));
    hde = (h >= int'(hDispStart)) && (h < int'(hDispStart) + int'(hActive));
    vde = (v >= int'(vDispStart)) && (v < int'(vDispStart) + int'(vActive));
    chk("R1", "hCount", int'(hCount), h);
    chk("R2", "lineNum", int'(lineNum), v);
    chk("R3/R5", "hSync", int'(hSync), syncPol[0] ? hs : int'(!hs));
    chk("R3/R5", "vSync", int'(vSync), syncPol[1] ? vs : int'(!vs));
    chk("R4", "dispEn", int'(dispEn), int'(en && hde && vde));
    chk("R6", "vSyncStat", int'(vSyncStat), vs);
    chk("R6", "vBlankStat", int'(vBlankStat), int'(!(en && vde)));
    chk("R7/R8", "matchStat", int'(matchStat), int'(expSticky));
    chk("R7", "irq", int'(irq), int'(expSticky && irqEn));
  endtask

  // Run nEdges clocks with enable high, starting from position 0
  task automatic sweep(input int nEdges, input int clrA, input int clrB);
    int tot;
    tot = int'(hTotal) * int'(vTotal);
    enable = 1'b1;
    for (int n = 1; n <= nEdges; n++) begin
      int prev, cur;
      matchClr = (n == clrA) || (n == clrB);
      @(posedge clk);
      @(negedge clk);
      matchClr = 1'b0;
      prev = (n - 1) % tot;
      cur  = n % tot;
      if ((prev % int'(hTotal)) == 0 && (prev / int'(hTotal)) == int'(matchLine))
        expSticky = 1'b1;                 // R7, set wins over clear (R8)
      else if (n == clrA || n == clrB)
        expSticky = 1'b0;                 // R8 clear
      checkPos(cur % int'(hTotal), cur / int'(hTotal), 1'b1);
    end
  endtask

  task automatic disableCheck();
    enable = 1'b0;
    @(posedge clk);
    @(negedge clk);
    checkPos(0, 0, 1'b0);                 // R9 hold, status kept
    @(posedge clk);
    @(negedge clk);
    checkPos(0, 0, 1'b0);                 // R9 still held
  endtask

  initial begin
    #(200000 * 10);
    if (!finished) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog: actual running expected finished");
      $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    checkPos(0, 0, 1'b0);                 // reset state, R9
    rst_n = 1'b1;
    @(negedge clk);
    checkPos(0, 0, 1'b0);

    // Config 1: 10 x 7 raster, active-low syncs, interrupt enabled
    hSyncEnd = 11'd2; hDispStart = 11'd4; hActive = 11'd4; hTotal = 11'd10;
    vSyncEnd = 10'd1; vDispStart = 10'd2; vActive = 10'd3; vTotal = 10'd7;
    syncPol = 2'b00; matchLine = 10'd5; irqEn = 1'b1;
    @(negedge clk);
    sweep(140, 60, -1);                   // R8 clear away from a match at edge 60
    disableCheck();

    // Config 2: 6 x 5 raster, active-high syncs, interrupt masked
    hSyncEnd = 11'd1; hDispStart = 11'd2; hActive = 11'd3; hTotal = 11'd6;
    vSyncEnd = 10'd2; vDispStart = 10'd3; vActive = 10'd2; vTotal = 10'd5;
    syncPol = 2'b11; matchLine = 10'd3; irqEn = 1'b0;
    @(negedge clk);
    sweep(75, 5, 19);                     // edge 19 is a match edge: R8 set wins
    disableCheck();

    // Config 3: mixed polarity, match on line 0, interrupt enabled
    syncPol = 2'b01; matchLine = 10'd0; irqEn = 1'b1;
    @(negedge clk);
    sweep(40, 3, 0);
    disableCheck();

    finished = 1'b1;
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end
endmodule